// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator and a 32-word on-chip memory. Every instruction passes through a fixed chain of register transfers, one transfer per clock: the program counter is copied into the memory address register, the addressed word is read into the memory data register, and that word moves into the instruction register. Two instructions do real work. One loads the accumulator from memory. The other adds a memory word to the accumulator and records the carry out of bit 7 in a one-bit overflow flag. The remaining six codes finish without effect.

The memory is filled through a preload write port while the core is held in reset. After reset is released the core runs from address 0 with no further input. Every architectural register is brought out as an observation output, together with a step code that shows which transfer the core is doing. A testbench or a debug view can therefore follow the machine one clock at a time.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `pc_o` = 0, `step_o` = 0 and `ovf_o` = 0. MAR, MDR, IR and the accumulator are not reset and count as unknown until they are first written.
- R2: The step code moves 0→1→2→3 on successive clocks. From 3 it goes to 4 for a load or an add, and to 0 for any other opcode. From 4 it goes to 5, and from 5 to 0.
- R3: In step 0, MAR takes the value of PC and PC increments by one. PC wraps from 31 to 0, and PC changes in no other step.
- R4: In step 1, MDR takes the memory word at MAR. In step 2, IR takes MDR.
- R5: An instruction word has its opcode in bits 7:5 and its operand address in bits 4:0. For a load or an add, step 3 copies IR bits 4:0 into MAR and step 4 reads the memory word at that address into MDR.
- R6: Opcode 5 (binary 101) writes MDR into the accumulator in step 5 and leaves the overflow flag unchanged.
- R7: Opcode 2 (binary 010) writes the low 8 bits of accumulator + MDR into the accumulator in step 5, and writes the carry out of bit 7 into the overflow flag. The flag is set when there is a carry and cleared when there is none.
- R8: Opcodes 0, 1, 3, 4, 6 and 7 take four steps (0 to 3) and change neither the accumulator nor the overflow flag.
- R9: When `pre_we` is high at a rising edge, `pre_data` is written into memory at `pre_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | 5 | Memory preload address |
| pre_data | input | 8 | Memory preload data |
| pc_o | output | 5 | Program counter |
| mar_o | output | 5 | Memory address register |
| mdr_o | output | 8 | Memory data register |
| ir_o | output | 8 | Instruction register |
| acc_o | output | 8 | Accumulator |
| ovf_o | output | 1 | Overflow (carry) flag |
| step_o | output | 3 | Active transfer step, 0 to 5 |

## Verification
The bench targets an add whose carry sets the flag followed by one whose lack of carry clears it. A core that only ever sets the flag would show a stale 1 after the second add. It also runs the program counter past address 31: a counter that saturates or grows wider would fetch from the wrong address and fail the MAR and IR checks after the wrap. Unused opcodes are mixed among loads and adds. A decoder that sends them through the operand steps would show up as a wrong step code and a delayed next fetch, and one that writes them back would corrupt the accumulator. A reset in the middle of an instruction checks that PC, the step code and the flag return to zero from any step.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int OP_W   = DATA_W - ADDR_W;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR = 3'd0,
    ST_FETCH_READ = 3'd1,
    ST_FETCH_IR   = 3'd2,
    ST_EXEC_ADDR  = 3'd3,
    ST_EXEC_READ  = 3'd4,
    ST_EXEC_WB    = 3'd5
  } step_t;

  localparam logic [OP_W-1:0] OP_LOAD = 3'd5;
  localparam logic [OP_W-1:0] OP_ADD  = 3'd2;

  function automatic logic op_uses_operand(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array with a registered read port (the MDR).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_core_pkg::*;
#(
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  output step_t          step
);
  step_t step_nxt;

  always_comb begin
    unique case (step)
      ST_FETCH_ADDR: step_nxt = ST_FETCH_READ;
      ST_FETCH_READ: step_nxt = ST_FETCH_IR;
      ST_FETCH_IR:   step_nxt = ST_EXEC_ADDR;
      ST_EXEC_ADDR:  step_nxt = op_uses_operand(op) ? ST_EXEC_READ : ST_FETCH_ADDR;
      ST_EXEC_READ:  step_nxt = ST_EXEC_WB;
      ST_EXEC_WB:    step_nxt = ST_FETCH_ADDR;
      default:       step_nxt = ST_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH_ADDR;
    else     step <= step_nxt;
  end
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_core_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  step_t         step,
  input  logic [DW-1:0] mdr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic          ovf
);
  localparam int OPW = DW - AW;

  logic [OPW-1:0] op;
  logic [DW:0]    sum;

  assign op  = ir[DW-1:AW];
  assign sum = {1'b0, acc} + {1'b0, mdr};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ovf <= 1'b0;
    end else begin
      unique case (step)
        ST_FETCH_ADDR: begin
          mar <= pc;
          pc  <= pc + AW'(1);
        end
        ST_FETCH_IR: ir <= mdr;
        ST_EXEC_ADDR: begin
          if (op_uses_operand(op)) mar <= ir[AW-1:0];
        end
        ST_EXEC_WB: begin
          if (op == OP_LOAD) begin
            acc <= mdr;
          end else if (op == OP_ADD) begin
            acc <= sum[DW-1:0];
            ovf <= sum[DW];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mdr_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] acc_o,
  output logic          ovf_o,
  output logic [2:0]    step_o
);
  localparam int OPW = DW - AW;

  step_t         step;
  logic          rd_en;
  logic [DW-1:0] mdr;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, acc;
  logic          ovf;

  assign rd_en = (step == ST_FETCH_READ) || (step == ST_EXEC_READ);

  acc_seq #(.OPW(OPW)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .op   (ir[DW-1:AW]),
    .step (step)
  );

  acc_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .re    (rd_en),
    .raddr (mar),
    .rdata (mdr)
  );

  acc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .mdr  (mdr),
    .pc   (pc),
    .mar  (mar),
    .ir   (ir),
    .acc  (acc),
    .ovf  (ovf)
  );

  assign pc_o   = pc;
  assign mar_o  = mar;
  assign mdr_o  = mdr;
  assign ir_o   = ir;
  assign acc_o  = acc;
  assign ovf_o  = ovf;
  assign step_o = step;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mar,
  input logic [DW-1:0] mdr,
  input logic [DW-1:0] ir,
  input logic [DW-1:0] acc,
  input logic          ovf,
  input logic [2:0]    step
);
  logic [DW-AW-1:0] op;
  assign op = ir[DW-1:AW];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0) && (step == 3'd0) && !ovf);

  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |=> (step == 3'd1));

  assert_fetch_ir_next_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd2) |=> (step == 3'd3));

  assert_exec_order_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd4) |=> (step == 3'd5));

  assert_exec_return_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd5) |=> (step == 3'd0));

  assert_pc_to_mar_R3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |=> (mar == $past(pc)) && (pc == AW'($past(pc) + 1'b1)));

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (step != 3'd0) |=> $stable(pc));

  assert_mdr_to_ir_R4: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd2) |=> (ir == $past(mdr)));

  assert_operand_addr_R5: assert property (@(posedge clk) disable iff (rst)
    ((step == 3'd3) && op_uses_operand(op)) |=> (mar == $past(ir[AW-1:0])));

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    ((step == 3'd5) && (op == OP_LOAD)) |=> (acc == $past(mdr)) && (ovf == $past(ovf)));

  assert_add_R7: assert property (@(posedge clk) disable iff (rst)
    ((step == 3'd5) && (op == OP_ADD)) |=>
      ({ovf, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mdr)})));

  assert_noop_short_R8: assert property (@(posedge clk) disable iff (rst)
    ((step == 3'd3) && !op_uses_operand(op)) |=> (step == 3'd0));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (step != 3'd5) |=> $stable(acc) && $stable(ovf));
endmodule

bind acc_core acc_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .pc   (pc_o),
  .mar  (mar_o),
  .mdr  (mdr_o),
  .ir   (ir_o),
  .acc  (acc_o),
  .ovf  (ovf_o),
  .step (step_o)
);

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre_we = 1'b0;
  logic [4:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic [4:0] pc_o, mar_o;
  logic [7:0] mdr_o, ir_o, acc_o;
  logic       ovf_o;
  logic [2:0] step_o;

  int  nvec = 0;
  int  nerr = 0;
  bit  done = 0;

  logic [7:0] mem_m [32];
  logic [4:0] m_pc;
  logic [7:0] m_acc;
  logic       m_ovf;
  bit         acc_known, ovf_known;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core uut (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o), .ir_o(ir_o), .acc_o(acc_o),
    .ovf_o(ovf_o), .step_o(step_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic preload(input logic [4:0] a, input logic [7:0] d);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    tick();
    pre_we = 1'b0;
    mem_m[a] = d;
  endtask

  function automatic logic [7:0] mk(input logic [2:0] op, input logic [4:0] a);
    return {op, a};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    check(pc_o == 5'd0, "R1", "pc after reset", pc_o, 0);
    check(step_o == 3'd0, "R1", "step after reset", step_o, 0);
    check(ovf_o == 1'b0, "R1", "ovf after reset", ovf_o, 0);
    m_pc = '0; m_ovf = 1'b0; ovf_known = 1; acc_known = 0;
    rst = 1'b0;
  endtask

  task automatic run_instr();
    logic [4:0] p0;
    logic [7:0] w;
    logic [2:0] op;
    logic [4:0] a;
    logic [8:0] s;
    p0 = m_pc; w = mem_m[p0]; op = w[7:5]; a = w[4:0];
    check(step_o == 3'd0, "R2", "step at fetch start", step_o, 0);
    check(pc_o == p0, "R3", "pc at fetch start", pc_o, p0);
    tick();
    check(mar_o == p0, "R3", "mar takes pc", mar_o, p0);
    check(pc_o == 5'(p0 + 5'd1), "R3", "pc increment/wrap", pc_o, 5'(p0 + 5'd1));
    check(step_o == 3'd1, "R2", "step 1", step_o, 1);
    tick();
    check(mdr_o == w, "R4", "mdr fetch read (R9 preload)", mdr_o, w);
    check(step_o == 3'd2, "R2", "step 2", step_o, 2);
    tick();
    check(ir_o == w, "R4", "ir takes mdr", ir_o, w);
    check(step_o == 3'd3, "R2", "step 3", step_o, 3);
    tick();
    if (op == 3'd5 || op == 3'd2) begin
      check(mar_o == a, "R5", "operand address to mar", mar_o, a);
      check(step_o == 3'd4, "R2", "step 4", step_o, 4);
      tick();
      check(mdr_o == mem_m[a], "R5", "operand read", mdr_o, mem_m[a]);
      check(step_o == 3'd5, "R2", "step 5", step_o, 5);
      tick();
      check(step_o == 3'd0, "R2", "return to fetch", step_o, 0);
      if (op == 3'd5) begin
        m_acc = mem_m[a]; acc_known = 1;
        check(acc_o == m_acc, "R6", "load acc", acc_o, m_acc);
        if (ovf_known) check(ovf_o == m_ovf, "R6", "load keeps ovf", ovf_o, m_ovf);
      end else if (acc_known) begin
        s = {1'b0, m_acc} + {1'b0, mem_m[a]};
        m_acc = s[7:0]; m_ovf = s[8]; ovf_known = 1;
        check(acc_o == m_acc, "R7", "add acc", acc_o, m_acc);
        check(ovf_o == m_ovf, "R7", "add carry flag", ovf_o, m_ovf);
      end else begin
        ovf_known = 0;
      end
    end else begin
      check(step_o == 3'd0, "R8", "unused opcode returns to fetch", step_o, 0);
      if (acc_known) check(acc_o == m_acc, "R8", "unused opcode keeps acc", acc_o, m_acc);
      if (ovf_known) check(ovf_o == m_ovf, "R8", "unused opcode keeps ovf", ovf_o, m_ovf);
    end
    m_pc = 5'(p0 + 5'd1);
  endtask

  function automatic logic [7:0] rand_word();
    logic [2:0] op;
    int r;
    r = int'($urandom % 4);
    if (r == 0)      op = 3'd5;
    else if (r == 1) op = 3'd2;
    else             op = 3'($urandom);
    return mk(op, 5'($urandom));
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // Directed program: load, carry-producing add, unused opcode, carry-free add.
    for (int i = 0; i < 32; i++) preload(5'(i), rand_word());
    preload(5'd0, mk(3'd5, 5'd20));
    preload(5'd1, mk(3'd2, 5'd21));
    preload(5'd2, mk(3'd7, 5'd21));
    preload(5'd3, mk(3'd2, 5'd22));
    preload(5'd4, mk(3'd0, 5'd0));
    preload(5'd20, 8'hC8);
    preload(5'd21, 8'h40);
    preload(5'd22, 8'h01);
    preload(5'd31, mk(3'd2, 5'd22));
    do_reset();
    run_instr();
    run_instr();
    check(ovf_o == 1'b1, "R7", "carry sets flag", ovf_o, 1);
    check(acc_o == 8'h08, "R7", "sum low byte", acc_o, 8'h08);
    run_instr();
    run_instr();
    check(ovf_o == 1'b0, "R7", "no carry clears flag", ovf_o, 0);
    check(acc_o == 8'h09, "R7", "sum 0x09", acc_o, 8'h09);
    // Continue past address 31 to cover the wrap.
    for (int i = 0; i < 36; i++) run_instr();

    // Reset in the middle of an instruction.
    tick();
    tick();
    do_reset();

    // Random programs.
    for (int prog = 0; prog < 4; prog++) begin
      rst = 1'b1;
      for (int i = 0; i < 32; i++) preload(5'(i), rand_word());
      preload(5'd0, mk(3'd5, 5'($urandom)));
      do_reset();
      for (int i = 0; i < 48; i++) run_instr();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule